// File: doc/BRIEF.md
# Four-Slot ADC Conversion Sequencer

This block drives an external successive-approximation converter: an analog multiplexer, a sample-and-hold, a DAC and a comparator. It runs the bit-by-bit search and stores four 8-bit results per sequence in four dedicated result slots. A sequence converts either one channel four times, or a group of four consecutive channels once each. The sequence can stop after one set or repeat without end. A completion flag tells software when a full set of four results is ready.

Software configures the block through two write ports. The options port powers the converter up and chooses the step clock. The control port picks the channel, the mode and scan repetition, and every accepted control write starts a new sequence. When the alternate oscillator is selected, the conversion steps follow that free-running clock through a synchronizer. Result writes are then held back while a bus read is in progress, so a read never sees a slot change under it.

Top module: `adc_seq_top`

## Requirements
- R1: After synchronous reset, `ccf`, `sampling` and `dac_code` are 0, all four result slots read 0, and the options are power-down (0) and bus-clock stepping (0).
- R2: While the power-up option is 0, a control write is ignored: no sampling starts, `ccf` stays 0 and the result slots keep their values.
- R3: The edge that accepts a control write starts the sample phase (`sampling`=1). Each conversion is one sample step, then eight bit steps, then a commit on the next edge. With bus-clock stepping, this gives ten cycles per result.
- R4: Bit steps run MSB first. During step i, `dac_code` shows the bits already kept, with bit i set as the trial bit. `comp_in`=1 at the step edge keeps the trial bit and 0 clears it. Outside bit steps, `dac_code` is 0.
- R5: With control bit 4 (multi) at 0, `mux_sel` equals control bits 3:0 for all four conversions, and results fill slots 0, 1, 2, 3 in order.
- R6: With multi at 1, `mux_sel` is {control bits 3:2, slot number}. Control bits 1:0 are ignored.
- R7: `ccf` becomes 1 on the edge that commits slot 3, and an accepted control write clears it.
- R8: With control bit 5 (scan) at 0, the block goes idle after slot 3. With scan at 1, it starts slot 0 again at once and `ccf` stays 1.
- R9: A control write accepted during a sequence aborts it, clears `ccf` and restarts at slot 0 on the next edge. Earlier results stay until they are overwritten.
- R10: Options bit 0 (alt-select) at 1 makes steps occur only on a bus edge where `alt_clk` was sampled 1 two edges earlier and 0 three edges earlier.
- R11: With alt-select at 1, a commit is held while `rd_en` is 1 and happens on the first edge where it is 0. With alt-select at 0, `rd_en` has no effect.
- R12: Writing options bit 1 (power-up) to 0 stops any conversion at the next edge. Results and `ccf` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_clk | input | 1 | Free-running alternate step oscillator, asynchronous |
| opt_we | input | 1 | Options write strobe |
| opt_din | input | 2 | Options: bit 1 power-up, bit 0 alt-select |
| ctl_we | input | 1 | Control write strobe, starts a sequence |
| ctl_din | input | 6 | Control: bit 5 scan, bit 4 multi, bits 3:0 channel |
| rd_en | input | 1 | Bus read in progress |
| rd_sel | input | 2 | Result slot to read |
| rd_data | output | 8 | Contents of the selected result slot |
| comp_in | input | 1 | Comparator: 1 when analog input is at or above `dac_code` |
| mux_sel | output | 4 | Analog multiplexer channel select |
| dac_code | output | 8 | Trial code for the DAC |
| sampling | output | 1 | Sample phase active |
| ccf | output | 1 | A set of four results is complete |

## Verification
A search register that drifts shows up within one cycle as a wrong `dac_code` trial pattern, and at the commit edge as a wrong slot value. A slot counter that goes wrong moves `mux_sel` in multi mode at once, and fills the wrong slot or raises `ccf` one conversion early or late. A mis-timed synchronizer or commit guard shifts every later step edge. In alt-select mode, it also changes a slot while `rd_en` is high. The reference model follows all of this cycle by cycle, with an ideal comparator on each channel's fixed level. Boundary levels 0x00 and 0xFF test the all-clear and all-keep searches.

// File: rtl/adc_seq_pkg.sv
// Shared types of the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_seq_pkg;

    // Phases of one conversion inside the search core
    typedef enum logic [1:0] {
        SAR_IDLE   = 2'd0,
        SAR_SAMPLE = 2'd1,
        SAR_STEP   = 2'd2,
        SAR_HOLD   = 2'd3
    } sar_state_e;

    // Control register field positions, derived from the channel width
    function automatic int scan_bit(input int ch_w);
        return ch_w + 1;
    endfunction

    function automatic int multi_bit(input int ch_w);
        return ch_w;
    endfunction

endpackage

// File: rtl/adc_clk_sync.sv
// Brings the free-running alternate oscillator into the bus domain.
// Emits a one-cycle pulse per rising edge it sees.
// Assumes: async_in is slow next to clk (at least two bus cycles per level).
module adc_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    // Shift the asynchronous level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_in};
    end

    // Rising edge seen after the last metastability stage
    always_comb rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R10
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/adc_sar_core.sv
// Runs one successive-approximation conversion: a sample step, then one
// step per bit from MSB down.
// Holds the value until the controller restarts or stops it.
// Assumes: start_i dominates stop_i; adv_i marks the cycles that may step.
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             adv_i,
    input  logic             comp_i,
    output logic             sampling_o,
    output logic             hold_o,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] value_o
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    sar_state_e       state_q;
    logic [RES_W-1:0] acc_q;
    logic [RES_W-1:0] mask_q;

    // Phase sequencing and the keep-or-clear decision per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SAR_IDLE;
            acc_q   <= '0;
            mask_q  <= '0;
        end else if (start_i) begin
            state_q <= SAR_SAMPLE;
            acc_q   <= '0;
            mask_q  <= '0;
        end else if (stop_i) begin
            state_q <= SAR_IDLE;
            mask_q  <= '0;
        end else begin
            case (state_q)
                SAR_SAMPLE: if (adv_i) begin
                    state_q <= SAR_STEP;
                    mask_q  <= TOP_BIT;
                end
                SAR_STEP: if (adv_i) begin
                    if (comp_i) acc_q <= acc_q | mask_q;
                    mask_q <= mask_q >> 1;
                    if (mask_q[0]) state_q <= SAR_HOLD;
                end
                default: ;
            endcase
        end
    end

    // Outputs toward the analog side and the controller
    always_comb begin
        sampling_o = (state_q == SAR_SAMPLE);
        hold_o     = (state_q == SAR_HOLD);
        trial_o    = (state_q == SAR_STEP) ? (acc_q | mask_q) : '0;
        value_o    = acc_q;
    end

    // R4
    last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SAR_STEP && adv_i && mask_q[0] && !start_i && !stop_i) |=> hold_o);

    // R10
    wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling_o && !adv_i && !start_i && !stop_i) |=> sampling_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
// Sequence controller. Holds the options and control registers, counts
// result slots, decides commits and restarts, and keeps the completion flag.
// Assumes: SLOTS is a power of two and CH_W is wider than the slot index.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int SLOTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opt_we,
    input  logic [1:0]        opt_din,
    input  logic              ctl_we,
    input  logic [CH_W+1:0]   ctl_din,
    input  logic              rd_en,
    input  logic              hold_i,
    output logic              start_o,
    output logic              stop_o,
    output logic              commit_o,
    output logic [$clog2(SLOTS)-1:0] slot_o,
    output logic [CH_W-1:0]   chan_o,
    output logic              csel_o,
    output logic              ccf_o
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CTL_W  = CH_W + 2;
    localparam int SCAN   = scan_bit(CH_W);
    localparam int MULTI  = multi_bit(CH_W);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic              adpu_q;
    logic              csel_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [SLOT_W-1:0] slot_q;
    logic              ccf_q;

    logic ctl_go;
    logic commit_ok;
    logic last_slot;
    logic again;

    // Accept, commit and restart decisions for this cycle
    always_comb begin
        ctl_go    = ctl_we & adpu_q;
        commit_ok = ~csel_q | ~rd_en;
        commit_o  = hold_i & commit_ok & adpu_q & ~ctl_go;
        last_slot = (slot_q == LAST_SLOT);
        again     = ~last_slot | ctl_q[SCAN];
        start_o   = ctl_go | (commit_o & again);
        stop_o    = ~adpu_q | (commit_o & ~again);
    end

    // Channel for the current slot: fixed, or group base plus slot
    always_comb begin
        if (ctl_q[MULTI]) chan_o = {ctl_q[CH_W-1:SLOT_W], slot_q};
        else              chan_o = ctl_q[CH_W-1:0];
    end

    // Options register: power-up and step-clock select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adpu_q <= 1'b0;
            csel_q <= 1'b0;
        end else if (opt_we) begin
            adpu_q <= opt_din[1];
            csel_q <= opt_din[0];
        end
    end

    // Control register, written only while powered up
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_go) ctl_q <= ctl_din;
    end

    // Slot counter and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            ccf_q  <= 1'b0;
        end else if (ctl_go) begin
            slot_q <= '0;
            ccf_q  <= 1'b0;
        end else if (commit_o) begin
            slot_q <= slot_q + SLOT_W'(1);
            if (last_slot) ccf_q <= 1'b1;
        end
    end

    always_comb begin
        slot_o = slot_q;
        csel_o = csel_q;
        ccf_o  = ccf_q;
    end

    // R7
    ccf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ccf_q) |-> ($past(commit_o) && $past(slot_q) == LAST_SLOT));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && adpu_q) |=> (!ccf_q && slot_q == '0));

    // R2
    powered_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adpu_q && !opt_we) |=> (!start_o && !commit_o));

endmodule

// File: rtl/adc_result_bank.sv
// Result storage: one register per slot, written at commit.
// Assumes: at most one slot is written per cycle.
module adc_result_bank #(
    parameter int RES_W = 8,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(SLOTS)-1:0] wr_slot,
    input  logic [RES_W-1:0]         wr_data,
    output logic [SLOTS*RES_W-1:0]   slots_o
);
    localparam int SLOT_W = $clog2(SLOTS);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [RES_W-1:0] res_q;

        // Capture the committed value when this slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n)                                   res_q <= '0;
            else if (wr_en && wr_slot == SLOT_W'(g))      res_q <= wr_data;
        end

        assign slots_o[g*RES_W +: RES_W] = res_q;
    end

endmodule

// File: rtl/adc_seq_top.sv
// Four-slot conversion sequencer top. It ties the step-clock synchronizer,
// the search core, the controller and the result bank together.
// Assumes: the external comparator settles within one bus cycle.
module adc_seq_top #(
    parameter int RES_W = 8,
    parameter int CH_W  = 4,
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alt_clk,
    input  logic                     opt_we,
    input  logic [1:0]               opt_din,
    input  logic                     ctl_we,
    input  logic [CH_W+1:0]          ctl_din,
    input  logic                     rd_en,
    input  logic [$clog2(SLOTS)-1:0] rd_sel,
    output logic [RES_W-1:0]         rd_data,
    input  logic                     comp_in,
    output logic [CH_W-1:0]          mux_sel,
    output logic [RES_W-1:0]         dac_code,
    output logic                     sampling,
    output logic                     ccf
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic              alt_rise;
    logic              csel;
    logic              adv;
    logic              start;
    logic              stop;
    logic              commit;
    logic              hold;
    logic [SLOT_W-1:0] slot;
    logic [RES_W-1:0]  value;
    logic [SLOTS*RES_W-1:0] bank_flat;

    adc_clk_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (alt_clk),
        .rise_o   (alt_rise)
    );

    // Step enable: every cycle, or only on synchronized oscillator edges
    always_comb adv = csel ? alt_rise : 1'b1;

    adc_sar_core #(.RES_W(RES_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .stop_i     (stop),
        .adv_i      (adv),
        .comp_i     (comp_in),
        .sampling_o (sampling),
        .hold_o     (hold),
        .trial_o    (dac_code),
        .value_o    (value)
    );

    adc_seq_ctrl #(.CH_W(CH_W), .SLOTS(SLOTS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opt_we   (opt_we),
        .opt_din  (opt_din),
        .ctl_we   (ctl_we),
        .ctl_din  (ctl_din),
        .rd_en    (rd_en),
        .hold_i   (hold),
        .start_o  (start),
        .stop_o   (stop),
        .commit_o (commit),
        .slot_o   (slot),
        .chan_o   (mux_sel),
        .csel_o   (csel),
        .ccf_o    (ccf)
    );

    adc_result_bank #(.RES_W(RES_W), .SLOTS(SLOTS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_slot (slot),
        .wr_data (value),
        .slots_o (bank_flat)
    );

    // Bus read of one result slot
    always_comb rd_data = bank_flat[rd_sel*RES_W +: RES_W];

    // R11
    read_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csel && rd_en) |=> $stable(bank_flat));

endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alt_clk = 1'b0;
    logic       opt_we = 1'b0;
    logic [1:0] opt_din = 2'b00;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_din = 6'd0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       comp_in;
    logic [3:0] mux_sel;
    logic [7:0] dac_code;
    logic       sampling;
    logic       ccf;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int wd = 0;
    bit rd_rot = 1'b1;
    int rd_mode = 0;
    logic [1:0] pk_sel = 2'd0;

    // fixed analog level per channel
    function automatic int ain_of(input int ch);
        if (ch == 3) return 255;
        if (ch == 9) return 0;
        return (ch * 53 + 17) % 256;
    endfunction

    assign comp_in = (ain_of(int'(mux_sel)) >= int'(dac_code));

    adc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk),
        .opt_we(opt_we), .opt_din(opt_din),
        .ctl_we(ctl_we), .ctl_din(ctl_din),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .comp_in(comp_in), .mux_sel(mux_sel), .dac_code(dac_code),
        .sampling(sampling), .ccf(ccf)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;
    initial begin
        #2;
        forever #15 alt_clk = ~alt_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // reference model state
    int m_adpu, m_csel, m_scan, m_multi, m_chan, m_slot, m_ccf, m_ph, m_bit;
    int m_res[4];
    int ah[$] = '{0, 0, 0};

    function automatic int chan_of(input int s);
        return (m_multi != 0) ? ((m_chan & 12) | s) : m_chan;
    endfunction

    function automatic int trial_of(input int a, input int b);
        return (((a >> (b + 1)) << (b + 1)) | (1 << b)) & 255;
    endfunction

    task automatic model_step();
        int adv, cok, n_adpu, n_csel;
        if (!rst_n) begin
            m_adpu = 0; m_csel = 0; m_scan = 0; m_multi = 0; m_chan = 0;
            m_slot = 0; m_ccf = 0; m_ph = 0; m_bit = 0;
            for (int i = 0; i < 4; i++) m_res[i] = 0;
            ah = '{0, 0, 0};
        end else begin
            adv = (m_csel != 0) ? int'(ah[1] == 1 && ah[2] == 0) : 1;
            cok = int'(m_csel == 0 || rd_en == 1'b0);
            n_adpu = m_adpu; n_csel = m_csel;
            if (opt_we) begin n_adpu = int'(opt_din[1]); n_csel = int'(opt_din[0]); end
            if (m_adpu == 0) m_ph = 0;
            else if (ctl_we) begin
                m_scan = int'(ctl_din[5]); m_multi = int'(ctl_din[4]); m_chan = int'(ctl_din[3:0]);
                m_slot = 0; m_ccf = 0; m_ph = 1;
            end else begin
                case (m_ph)
                    1: if (adv != 0) begin m_ph = 2; m_bit = 7; end
                    2: if (adv != 0) begin
                        if (m_bit == 0) m_ph = 3; else m_bit--;
                    end
                    3: if (cok != 0) begin
                        m_res[m_slot] = ain_of(chan_of(m_slot));
                        if (m_slot == 3) begin
                            m_ccf = 1; m_slot = 0;
                            m_ph = (m_scan != 0) ? 1 : 0;
                        end else begin
                            m_slot++; m_ph = 1;
                        end
                    end
                    default: ;
                endcase
            end
            m_adpu = n_adpu; m_csel = n_csel;
            ah.push_front(int'(alt_clk));
            void'(ah.pop_back());
        end
    endtask

    // model update at the edge, comparison shortly after
    always @(posedge clk) begin
        int e_dac;
        model_step();
        #2;
        e_dac = (m_ph == 2) ? trial_of(ain_of(chan_of(m_slot)), m_bit) : 0;
        chk(sampling == (m_ph == 1), "R3 sampling", int'(sampling), int'(m_ph == 1));
        chk(int'(dac_code) == e_dac, "R4 dac_code", int'(dac_code), e_dac);
        chk(int'(mux_sel) == chan_of(m_slot), (m_multi != 0) ? "R6 mux_sel" : "R5 mux_sel",
            int'(mux_sel), chan_of(m_slot));
        chk(int'(ccf) == m_ccf, "R7 ccf", int'(ccf), m_ccf);
        chk(int'(rd_data) == m_res[rd_sel], (m_csel != 0) ? "R10 rd_data" : "R8 rd_data",
            int'(rd_data), m_res[rd_sel]);
    end

    // read-side stimulus: slot select and read strobe pattern
    always @(negedge clk) begin
        cyc++;
        rd_sel <= rd_rot ? rd_sel + 2'd1 : pk_sel;
        case (rd_mode)
            1:       rd_en <= ((cyc % 7) < 4);
            2:       rd_en <= 1'b1;
            default: rd_en <= 1'b0;
        endcase
    end

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, WD_LIMIT);
            summary();
        end
    end

    task automatic wr_opt(input logic pu, input logic alt);
        @(negedge clk); opt_we = 1'b1; opt_din = {pu, alt};
        @(negedge clk); opt_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic scan, input logic multi, input logic [3:0] ch);
        @(negedge clk); ctl_we = 1'b1; ctl_din = {scan, multi, ch};
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic peek(input int s, input int exp, input string tag);
        rd_rot = 1'b0; pk_sel = 2'(s);
        @(negedge clk); @(negedge clk); #1;
        chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
        rd_rot = 1'b1;
    endtask

    task automatic wait_ccf(input int lim, output int n);
        n = 0;
        while (!ccf && n < lim) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(!ccf && !sampling && dac_code == 0, "R1 idle outputs", int'(ccf) + int'(sampling), 0);
        for (int i = 0; i < 4; i++) peek(i, 0, "R1 slot");

        // R2 control write ignored while powered down
        wr_ctl(1'b0, 1'b0, 4'd3);
        repeat (30) @(negedge clk); #1;
        chk(!ccf && !sampling, "R2 no start", int'(ccf) + int'(sampling), 0);
        peek(0, 0, "R2 slot kept");

        // R5 single channel, one shot, all-ones level
        wr_opt(1'b1, 1'b0);
        wr_ctl(1'b0, 1'b0, 4'd3); #1;
        chk(sampling == 1'b1, "R3 sample starts", int'(sampling), 1);
        wait_ccf(200, n);
        chk(ccf == 1'b1, "R7 ccf set", int'(ccf), 1);
        repeat (15) @(negedge clk); #1;
        chk(!sampling, "R8 one-shot idle", int'(sampling), 0);
        for (int i = 0; i < 4; i++) peek(i, 255, "R5 slot");

        // R6 group mode, low select bits ignored
        wr_ctl(1'b0, 1'b1, 4'd7);
        wait_ccf(200, n);
        for (int i = 0; i < 4; i++) peek(i, ain_of(4 + i), "R6 slot");

        // R8 scan on all-zero level, then R9 abort
        wr_ctl(1'b1, 1'b0, 4'd9);
        repeat (100) @(negedge clk); #1;
        chk(ccf == 1'b1, "R8 scan ccf held", int'(ccf), 1);
        peek(2, 0, "R4 zero level");
        wr_ctl(1'b0, 1'b0, 4'd10); #1;
        chk(!ccf && sampling, "R9 abort restart", int'(ccf), 0);
        wait_ccf(200, n);
        for (int i = 0; i < 4; i++) peek(i, ain_of(10), "R9 slot");

        // R11 bus-clock stepping ignores read strobe
        rd_mode = 2;
        wr_ctl(1'b0, 1'b0, 4'd5);
        wait_ccf(200, n);
        chk(n <= 45, "R11 no deferral", n, 45);
        rd_mode = 0;

        // R12 power-down mid scan
        wr_ctl(1'b1, 1'b1, 4'd12);
        repeat (15) @(negedge clk);
        wr_opt(1'b0, 1'b0);
        repeat (20) @(negedge clk); #1;
        chk(!sampling && dac_code == 0 && !ccf, "R12 halted", int'(sampling), 0);

        // R10 alternate stepping with read traffic
        wr_opt(1'b1, 1'b1);
        rd_mode = 1;
        wr_ctl(1'b0, 1'b1, 4'd8);
        wait_ccf(600, n);
        chk(n > 80, "R10 slower pace", n, 81);
        for (int i = 0; i < 4; i++) peek(i, ain_of(8 + i), "R10 slot");

        // R11 commit held while read strobe stays high
        rd_mode = 2;
        wr_ctl(1'b0, 1'b0, 4'd1);
        repeat (200) @(negedge clk); #1;
        chk(!ccf, "R11 commit held", int'(ccf), 0);
        peek(0, ain_of(8), "R11 slot unchanged");
        rd_mode = 0;
        wait_ccf(300, n);
        chk(ccf == 1'b1, "R11 commit resumes", int'(ccf), 1);
        peek(3, ain_of(1), "R11 slot filled");

        summary();
    end
endmodule